// File: doc/BRIEF.md
# Linked Master/Slave Tick Timers

This block holds two 32-bit up-counters, a master and a slave, behind one 4-bit nibble bus. A single-cycle `tick_en` strobe stands in for an 8192 Hz time base. On each strobe, every counter that is enabled adds one. A counter wraps from all ones back to zero. In normal use the master runs all the time as a tick counter. The slave stays stopped and is started only to pace a blinking cursor.

Each counter has its own 16-nibble register area. The area holds a 4-bit control nibble, whose bit 0 is the run flag, and the counter itself. The counter is seen as eight nibbles, least significant first. The slave's run condition is its own run flag ANDed with the master's run flag. Stopping the master therefore freezes the slave as well. Reads are combinational. Writes take effect at the clock edge. A nibble write touches only the addressed nibble and takes priority over a tick in the same cycle.

Top module: `linked_tick_timers`

## Requirements
- R1: After reset both control nibbles and both counters read as 0.
- R2: The master area starts at nibble address 0x10 and the slave area at 0x20. Within an area, the control nibble sits at offset 0. Counter nibble k (k = 0..7, k = 0 least significant) sits at offset 8+k.
- R3: On a clock edge with `tick_en` high and master run flag (control bit 0) set, the master counter adds one. With either of these low, it holds its value.
- R4: The slave counter adds one on a tick only when both its own run flag and the master run flag are set. With the master flag clear, it holds its value even when its own flag is set.
- R5: A counter at 0xFFFFFFFF that is ticked becomes 0x00000000.
- R6: A write to a counter nibble changes only that nibble. In a cycle where a counter nibble is written, that counter does not increment.
- R7: A write to a control nibble stores all four bits, and the same value reads back.
- R8: Any address outside both areas, and offsets 1 to 7 inside an area, read as 0 with `hit` low. A write there changes nothing.
- R9: `hit` is high whenever `addr` selects a control nibble or a counter nibble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle time-base strobe |
| wr_en | input | 1 | Nibble write strobe |
| addr | input | 8 | Nibble address |
| wdata | input | 4 | Write data |
| rdata | output | 4 | Combinational read data of the addressed nibble |
| hit | output | 1 | Address selects a register of this block |

## Verification
The bench writes distinct values to several nibbles of one counter and reads them back. A design with the nibble order reversed, or with the wrong offsets, returns the wrong nibble. It sets the slave run flag while the master is stopped and ticks. A slave that ignored the master flag would move when it should hold. It ticks a counter loaded with all ones, where a bad carry leaves stray bits set. It also writes a nibble in the same cycle as a tick. A design that let the increment win, or that rewrote the whole word, would show a changed count.

// File: rtl/linked_tick_timers.sv
module linked_tick_timers #(
  parameter int CNT_W = 32,
  parameter int NIB_W = 4,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] MST_BASE = 8'h10,
  parameter logic [ADDR_W-1:0] SLV_BASE = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NIB_W-1:0]  wdata,
  output logic [NIB_W-1:0]  rdata,
  output logic              hit
);
  localparam int NIBS  = CNT_W / NIB_W;
  localparam int IDX_W = $clog2(NIBS);
  localparam int OFS_W = IDX_W + 1;

  logic [CNT_W-1:0] cnt [2];
  logic [NIB_W-1:0] ctl [2];
  logic [1:0] ctl_hit, cnt_hit;

  wire [OFS_W-1:0] ofs = addr[OFS_W-1:0];
  wire [IDX_W-1:0] idx = ofs[IDX_W-1:0];
  wire run_m = ctl[0][0];
  wire run_s = ctl[0][0] & ctl[1][0];

  for (genvar c = 0; c < 2; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] BASE = (c == 0) ? MST_BASE : SLV_BASE;
    logic [CNT_W-1:0] q;
    logic [NIB_W-1:0] r;
    wire sel  = addr[ADDR_W-1:OFS_W] == BASE[ADDR_W-1:OFS_W];
    wire step = tick_en & ((c == 0) ? run_m : run_s);

    assign ctl_hit[c] = sel && (ofs == '0);
    assign cnt_hit[c] = sel && ofs[OFS_W-1];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= '0;
        r <= '0;
      end else begin
        if (wr_en && ctl_hit[c]) r <= wdata;
        if (wr_en && cnt_hit[c]) q[idx*NIB_W +: NIB_W] <= wdata;
        else if (step) q <= q + 1'b1;
      end
    end

    assign cnt[c] = q;
    assign ctl[c] = r;
  end

  always_comb begin
    rdata = '0;
    for (int c = 0; c < 2; c++) begin
      if (ctl_hit[c]) rdata = ctl[c];
      if (cnt_hit[c]) rdata = cnt[c][idx*NIB_W +: NIB_W];
    end
  end

  assign hit = |{ctl_hit, cnt_hit};
endmodule

// File: rtl/linked_tick_timers_chk.sv
module linked_tick_timers_chk #(
  parameter int CNT_W = 32,
  parameter int NIB_W = 4,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] MST_BASE = 8'h10,
  parameter logic [ADDR_W-1:0] SLV_BASE = 8'h20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [NIB_W-1:0]  wdata,
  input logic [NIB_W-1:0]  rdata,
  input logic              hit,
  input logic [CNT_W-1:0]  cnt_m,
  input logic [CNT_W-1:0]  cnt_s,
  input logic [NIB_W-1:0]  ctl_m,
  input logic [NIB_W-1:0]  ctl_s
);
  localparam int OFS_W = $clog2(CNT_W / NIB_W) + 1;
  wire outside = (addr[ADDR_W-1:OFS_W] != MST_BASE[ADDR_W-1:OFS_W]) &&
                 (addr[ADDR_W-1:OFS_W] != SLV_BASE[ADDR_W-1:OFS_W]);

  a_r3_master_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && tick_en && ctl_m[0]) |=> cnt_m == $past(cnt_m) + 1'b1);
  a_r3_master_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !(tick_en && ctl_m[0])) |=> $stable(cnt_m));
  a_r4_slave_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !ctl_m[0]) |=> $stable(cnt_s));
  a_r4_slave_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && tick_en && ctl_m[0] && ctl_s[0]) |=> cnt_s == $past(cnt_s) + 1'b1);
  a_r7_ctl_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == MST_BASE) |=> ctl_m == $past(wdata));
  a_r8_outside_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    outside |-> (!hit && rdata == '0));
endmodule

bind linked_tick_timers linked_tick_timers_chk #(
  .CNT_W(CNT_W), .NIB_W(NIB_W), .ADDR_W(ADDR_W),
  .MST_BASE(MST_BASE), .SLV_BASE(SLV_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
  .addr(addr), .wdata(wdata), .rdata(rdata), .hit(hit),
  .cnt_m(cnt[0]), .cnt_s(cnt[1]), .ctl_m(ctl[0]), .ctl_s(ctl[1])
);

// File: tb/sim_linked_tick_timers.sv
module sim_linked_tick_timers;
  logic clk = 0, rst_n = 0, tick_en = 0, wr_en = 0;
  logic [7:0] addr = 8'hFF;
  logic [3:0] wdata = 0;
  logic [3:0] rdata;
  logic hit;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  linked_tick_timers u0 (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .hit(hit));

  localparam logic [1:0] OP_W = 2'd1, OP_R = 2'd2, OP_T = 2'd3;
  localparam int NV = 16;
  // {op, addr, data}: write data / expected read / tick count
  localparam logic [13:0] VEC [NV] = '{
    {OP_R, 8'h10, 4'h0}, {OP_R, 8'h18, 4'h0},
    {OP_W, 8'h18, 4'h1}, {OP_W, 8'h19, 4'h2}, {OP_W, 8'h1F, 4'h8},
    {OP_R, 8'h18, 4'h1}, {OP_R, 8'h19, 4'h2}, {OP_R, 8'h1A, 4'h0}, {OP_R, 8'h1F, 4'h8},
    {OP_W, 8'h10, 4'h5}, {OP_R, 8'h10, 4'h5},
    {OP_T, 8'h00, 4'h3},
    {OP_R, 8'h18, 4'h4}, {OP_R, 8'h19, 4'h2}, {OP_R, 8'h13, 4'h0}, {OP_R, 8'h40, 4'h0}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [3:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1;
      @(negedge clk); tick_en = 0;
    end
  endtask

  task automatic rd32(input logic [7:0] base, output logic [31:0] v);
    logic [3:0] d;
    for (int k = 0; k < 8; k++) begin
      rd(base + 8'd8 + 8'(k), d);
      v[k*4 +: 4] = d;
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [3:0] d;
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][13:12])
        OP_W: wr(VEC[i][11:4], VEC[i][3:0]);
        OP_T: ticks(int'(VEC[i][3:0]));
        default: begin
          rd(VEC[i][11:4], d);
          chk(32'(d), 32'(VEC[i][3:0]), $sformatf("R1/R2/R3/R6/R7/R8 table[%0d]", i));
        end
      endcase
    end

    rd32(8'h10, v); chk(v, 32'h8000_0024, "R2 nibble order after ticks");
    rd32(8'h20, v); chk(v, 32'h0, "R4 slave idle");

    rd(8'h10, d); chk(32'(hit), 1, "R9 hit control");
    rd(8'h2B, d); chk(32'(hit), 1, "R9 hit slave counter");
    rd(8'h14, d); chk(32'(hit), 0, "R8 gap no hit");
    rd(8'h55, d); chk(32'(hit), 0, "R8 outside no hit");
    wr(8'h55, 4'hF); wr(8'h23, 4'hF);
    rd32(8'h20, v); chk(v, 32'h0, "R8 stray write ignored");
    rd32(8'h10, v); chk(v, 32'h8000_0024, "R8 stray write master unchanged");

    for (int k = 0; k < 8; k++) wr(8'h18 + 8'(k), 4'hF);
    ticks(1);
    rd32(8'h10, v); chk(v, 32'h0, "R5 wrap to zero");

    wr(8'h10, 4'h0); wr(8'h20, 4'h1);
    ticks(5);
    rd32(8'h20, v); chk(v, 32'h0, "R4 slave frozen while master stopped");
    rd32(8'h10, v); chk(v, 32'h0, "R3 master holds when stopped");
    wr(8'h10, 4'h1);
    ticks(3);
    rd32(8'h20, v); chk(v, 32'h3, "R4 slave runs with master");
    rd32(8'h10, v); chk(v, 32'h3, "R3 master counts");
    wr(8'h20, 4'h0);
    ticks(2);
    rd32(8'h20, v); chk(v, 32'h3, "R4 slave own flag clear");
    rd32(8'h10, v); chk(v, 32'h5, "R3 master keeps counting");

    wr(8'h19, 4'h7);
    @(negedge clk); wr_en = 1; tick_en = 1; addr = 8'h18; wdata = 4'hA;
    @(negedge clk); wr_en = 0; tick_en = 0;
    rd32(8'h10, v); chk(v, 32'h0000_007A, "R6 write beats tick");

    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd32(8'h10, v); chk(v, 32'h0, "R1 master cleared");
    rd(8'h10, d); chk(32'(d), 0, "R1 control cleared");
    summary();
  end
endmodule